// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two WIDTH-bit two's-complement operands and returns their 2*WIDTH-bit signed product. It uses a single accumulator register and one adder of product width. It adds one partial product per clock cycle, walking the multiplier from its least significant bit upward. Each partial product is the multiplicand, sign-extended to product width and shifted left by the bit's position, or zero when that multiplier bit is clear. The partial product belonging to the multiplier's top bit is subtracted instead of added, because that bit carries negative weight. Operands of either sign therefore need no separate magnitude or sign-fix step. Carries out of the top product bit are dropped.

A user pulses `start` with both operands present. The block then reports `busy` for WIDTH cycles and raises `done` for exactly one cycle once the final partial product has been absorbed. `product` keeps that result until the next accepted start.

The controller has three states:
- `ST_IDLE`: waiting. An accepted `start` moves it to `ST_RUN` (transition *launch*).
- `ST_RUN`: one multiplier bit is absorbed per cycle. It stays in `ST_RUN` while bits remain (*iterate*) and moves to `ST_FIN` after the top bit (*complete*).
- `ST_FIN`: the single `done` cycle. A `start` in this cycle moves straight back to `ST_RUN` (*relaunch*); otherwise the controller returns to `ST_IDLE` (*retire*).

Synchronous reset forces `ST_IDLE` from any state.

Top module: `smul_seq`

## Requirements
- R1: After a run, `product` equals the two's-complement product of the latched operands, truncated to 2*WIDTH bits, for every sign combination.
- R2: A `start` seen while `busy` is low captures `op_a` and `op_b` and clears the accumulator. In the next cycle `busy` is 1 and `product` is 0, and later changes on `op_a`/`op_b` do not alter the result.
- R3: `done` rises exactly WIDTH clock edges after the edge that accepted `start`. `busy` is high for those WIDTH cycles.
- R4: A negative multiplier (top bit of `op_b` set) gives the correct signed product, including the most negative value.
- R5: A negative multiplicand (top bit of `op_a` set) gives the correct signed product. Its partial products are sign-extended to full width.
- R6: Carries out of product bit 2*WIDTH-1 are discarded, so results such as (-2^(WIDTH-1))^2 appear correctly in 2*WIDTH bits.
- R7: `done` is high for exactly one cycle. `product` then stays unchanged while no new `start` is accepted.
- R8: `start` asserted while `busy` is high is ignored: the run neither restarts nor changes its result or its length.
- R9: Synchronous reset `rst` puts the block in idle, with `busy` = 0, `done` = 0 and `product` = 0 in the following cycle, even in the middle of a run.
- R10: A `start` in the `done` cycle is accepted. The next run begins at once (`busy` = 1 and `product` = 0 the following cycle) and yields its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication with the present operands |
| op_a | input | WIDTH | Multiplicand, two's complement |
| op_b | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while partial products are being accumulated |
| done | output | 1 | One-cycle pulse: `product` holds the finished result |
| product | output | 2*WIDTH | Accumulator contents; the signed product after `done` |

## Verification
The completion pulse of one run and the acceptance of a new request can fall in the same cycle, because `start` is honoured in `ST_FIN`. The bench provokes this by raising `start` with fresh operands at the very sample where it first sees `done`. It judges the overlap from three observations: `busy` is set and `product` reads zero one cycle later, the new run again takes exactly WIDTH edges, and its product matches a value computed independently in the bench. A second overlap, `start` arriving during `ST_RUN`, is checked by showing that neither the run's length nor its result moves.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } smul_state_e;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    output logic                          load,
    output logic                          step,
    output logic                          last,
    output logic [$clog2(WIDTH)-1:0]      bit_idx,
    output logic                          busy,
    output logic                          done
);

    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    smul_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;                 // launch
            ST_RUN:  if (cnt_q == LAST_IDX) state_d = ST_FIN;     // complete / iterate
            ST_FIN:  state_d = start ? ST_RUN : ST_IDLE;          // relaunch / retire
            default: state_d = ST_IDLE;
        endcase
    end

    // bit counter
    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + CW'(1);
    end

    // outputs decoded from state
    always_comb begin
        busy    = (state_q == ST_RUN);
        done    = (state_q == ST_FIN);
        load    = start && (state_q != ST_RUN);
        step    = (state_q == ST_RUN);
        last    = step && (cnt_q == LAST_IDX);
        bit_idx = cnt_q;
    end

    // R7: completion flag lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a request during a run only lets the count advance
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !last) |=> (busy && cnt_q == $past(cnt_q) + CW'(1)));

    // R3: completion only follows the top-bit step
    a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(last));

endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]          mcand,
    input  logic                      mbit,
    input  logic [$clog2(WIDTH)-1:0]  shift,
    input  logic                      negate,
    output logic [2*WIDTH-1:0]        addend
);

    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] widened;
    logic [PW-1:0] placed;

    always_comb begin
        widened = {{WIDTH{mcand[WIDTH-1]}}, mcand};
        placed  = mbit ? (widened << shift) : '0;
        addend  = negate ? (~placed + PW'(1)) : placed;
    end

endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic                          step,
    input  logic                          last,
    input  logic [$clog2(WIDTH)-1:0]      bit_idx,
    input  logic [WIDTH-1:0]              a_in,
    input  logic [WIDTH-1:0]              b_in,
    output logic [2*WIDTH-1:0]            acc
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic [PW-1:0]    acc_q;
    logic [PW-1:0]    addend;

    smul_ppgen #(.WIDTH(WIDTH)) u_ppgen (
        .mcand  (mcand_q),
        .mbit   (mplier_q[bit_idx]),
        .shift  (bit_idx),
        .negate (last),
        .addend (addend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            mcand_q  <= a_in;
            mplier_q <= b_in;
            acc_q    <= '0;
        end else if (step) begin
            acc_q    <= acc_q + addend;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WIDTH-1:0]     op_a,
    input  logic [WIDTH-1:0]     op_b,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);

    localparam int CW = $clog2(WIDTH);

    logic          load, step, last;
    logic [CW-1:0] bit_idx;

    smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .load    (load),
        .step    (step),
        .last    (last),
        .bit_idx (bit_idx),
        .busy    (busy),
        .done    (done)
    );

    smul_accum #(.WIDTH(WIDTH)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step),
        .last    (last),
        .bit_idx (bit_idx),
        .a_in    (op_a),
        .b_in    (op_b),
        .acc     (product)
    );

    // R2: accepted request starts a run from a cleared accumulator
    a_r2_launch_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && product == '0));

    // R7: result held while nothing new is accepted
    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    // R9: reset lands in idle with a zero result
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && product == '0));

endmodule

// File: tb/smul_seq_test.sv
`timescale 1ns/1ps
module smul_seq_test;

    localparam int W  = 8;
    localparam int NV = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [W-1:0]      op_a = '0;
    logic [W-1:0]      op_b = '0;
    logic              busy, done;
    logic [2*W-1:0]    product;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    localparam logic signed [W-1:0] VA [NV] = '{
        8'sd6, -8'sd6, 8'sd3, -8'sd6, 8'sd0, -8'sd128,
        -8'sd128, 8'sd127, -8'sd1, 8'sd1, 8'sd127, 8'sd85 };
    localparam logic signed [W-1:0] VB [NV] = '{
        8'sd3, 8'sd3, -8'sd6, -8'sd3, -8'sd128, -8'sd128,
        8'sd127, 8'sd127, -8'sd1, -8'sd128, -8'sd1, -8'sd86 };

    smul_seq #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product)
    );

    always #10 clk = ~clk;

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] ea, eb;
        ea = $signed(a);
        eb = $signed(b);
        return ea * eb;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // caller stands at a negedge; drives start for one edge
    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a  = ~a;   // must not matter after capture
        op_b  = ~b;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        int cyc;
        logic [2*W-1:0] expv, held;

        // reset state, R9
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && product == '0, "R9", "reset state", product, 0);

        // vector table, R1 R4 R5 R6 R2 R3 R7
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (VB[i][W-1]) ? "R4" : (VA[i][W-1]) ? "R5" : "R1";
            if (VA[i] == -8'sd128 && VB[i] == -8'sd128) tag = "R6";
            expv = ref_mul(VA[i], VB[i]);
            @(negedge clk);
            launch(VA[i], VB[i]);
            chk(busy && product == '0, "R2", "launch state", product, 0);
            wait_done(cyc);
            chk(cyc == W, "R3", "run length", cyc, W);
            chk(product == expv, tag, $sformatf("product %0d*%0d", VA[i], VB[i]),
                $signed(product), $signed(expv));
            held = product;
            @(negedge clk);
            chk(!done && product == held, "R7", "done pulse/hold", product, held);
            @(negedge clk);
            chk(product == held, "R7", "hold while idle", product, held);
        end

        // R8: start while busy ignored
        expv = ref_mul(8'sd37, -8'sd19);
        @(negedge clk);
        launch(8'sd37, -8'sd19);
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            start = (cyc >= 3 && cyc < 5);
            op_a  = 8'sd5;
            op_b  = 8'sd5;
        end
        start = 1'b0;
        chk(cyc == W, "R8", "run length with mid-run start", cyc, W);
        chk(product == expv, "R8", "product with mid-run start", $signed(product), $signed(expv));

        // R10: start in the done cycle
        launch(-8'sd9, 8'sd11);
        chk(busy && !done && product == '0, "R10", "relaunch state", product, 0);
        wait_done(cyc);
        expv = ref_mul(-8'sd9, 8'sd11);
        chk(cyc == W, "R10", "relaunch run length", cyc, W);
        chk(product == expv, "R10", "relaunch product", $signed(product), $signed(expv));

        // R9: reset mid-run
        @(negedge clk);
        launch(-8'sd100, -8'sd77);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && product == '0, "R9", "mid-run reset", product, 0);
        @(negedge clk);
        chk(!done && product == '0, "R9", "idle after reset", product, 0);
        launch(-8'sd100, -8'sd77);
        wait_done(cyc);
        expv = ref_mul(-8'sd100, -8'sd77);
        chk(product == expv, "R9", "run after reset", $signed(product), $signed(expv));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule